// File: doc/BRIEF.md
# Flow-Controlled DMA Word FIFO

This block is a synchronous word FIFO placed between a DMA engine and fabric logic. The DMA fills it through the write port on the transmit channel and empties it through the read port on the receive channel; channel names follow the DMA's point of view. For each channel the block drives two request lines toward the DMA. One line asks for a single-word transfer and the other asks for a block transfer. Both lines are derived from the fill level and a programmable block length.

The block length is a count of data words. It must match the length programmed in the DMA channel. Each channel has an acknowledge input, a one-cycle pulse sent by the DMA after a transfer or a flush. The pulse drops that channel's requests for a cycle so that the same transfer is never requested twice. The pulse never changes the stored data. Writes into a full FIFO and reads from an empty FIFO are dropped, and each raises a sticky error flag that stays set until it is cleared.

Top module: `dma_req_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, the FIFO empties (`level` = 0), all four request outputs go low, both error flags clear and `burst_size` returns to DEPTH.
- R2: Words leave in the order they were written. `rd_data` always shows the oldest stored word while `level` > 0, and a read with `rd_en` high pops that word at the clock edge.
- R3: A write with `wr_en` high while `level` = DEPTH is dropped: contents and level stay unchanged apart from a read in the same cycle, and `err_ovf` is set at that edge.
- R4: A read with `rd_en` high while `level` = 0 is dropped, and `err_udf` is set at that edge. A write in the same cycle is still accepted.
- R5: `tx_single` is registered. At each edge it takes the value (`level` < DEPTH) computed from the level held before that edge.
- R6: `rx_single` is registered. At each edge it takes the value (`level` > 0) computed from the level held before that edge.
- R7: `tx_burst` is registered. At each edge it takes the value (DEPTH − `level` ≥ `burst_size`) computed from the values held before that edge.
- R8: `rx_burst` is registered. At each edge it takes the value (`level` ≥ `burst_size`) computed from the values held before that edge.
- R9: When a channel's ack input is high at an edge, both request outputs of that channel are low for the following cycle. The other channel is not affected.
- R10: An ack pulse, whether it acknowledges a transfer or a flush, never changes `level` or the stored words.
- R11: A write to the block-length register with `cfg_we` applies at the next edge. A value of 0, or one above DEPTH, is stored as DEPTH, so `burst_size` always lies in 1..DEPTH.
- R12: `err_ovf` and `err_udf` stay set until a cycle with `err_clr` high. A new error in the clearing cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe (transmit-channel data from the DMA) |
| wr_data | input | DATA_W | Word to store |
| rd_en | input | 1 | Read strobe (pops the head word) |
| rd_data | output | DATA_W | Oldest stored word |
| level | output | CNT_W | Number of stored words |
| cfg_we | input | 1 | Block-length register write strobe |
| cfg_len | input | CNT_W | Requested block length in words |
| burst_size | output | CNT_W | Effective (clamped) block length |
| tx_ack | input | 1 | Transmit-channel acknowledge pulse |
| tx_single | output | 1 | Transmit single-word request |
| tx_burst | output | 1 | Transmit block request |
| rx_ack | input | 1 | Receive-channel acknowledge pulse |
| rx_single | output | 1 | Receive single-word request |
| rx_burst | output | 1 | Receive block request |
| err_clr | input | 1 | Clears both error flags |
| err_ovf | output | 1 | Sticky overflow flag |
| err_udf | output | 1 | Sticky underflow flag |

## Verification
On every cycle, the assertions check that an ack silences its own channel in the next cycle and that the single requests follow the previous fill level. They also check that a dropped write or read leaves the level pinned and raises its flag, that error flags hold until cleared, and that the block length stays within range. Word ordering, the block thresholds at the exact boundary, and the clamping of out-of-range lengths are shown only by the bench scenarios. Those scenarios compare every output against a reference model of the queue.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;

   typedef enum logic {
      DIR_TX = 1'b0,
      DIR_RX = 1'b1
   } dmaf_dir_e;

   // Maps a requested block length onto 1..depth (0 or oversize -> depth).
   function automatic int unsigned clamp_len(input int unsigned req,
                                             input int unsigned depth);
      if (req == 0 || req > depth) return depth;
      return req;
   endfunction

endpackage

// File: rtl/dmaf_store.sv
module dmaf_store #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   parameter int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  level,
   output logic              ovf_evt,
   output logic              udf_evt
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wp_q, rp_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              is_full, is_empty, do_wr, do_rd;

   assign is_full  = (cnt_q == FULL_C);
   assign is_empty = (cnt_q == '0);
   assign do_wr    = wr_en && !is_full;
   assign do_rd    = rd_en && !is_empty;
   assign ovf_evt  = wr_en && is_full;
   assign udf_evt  = rd_en && is_empty;
   assign rd_data  = mem[rp_q];
   assign level    = cnt_q;

   always_ff @(posedge clk) begin
      if (do_wr) mem[wp_q] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_wr) wp_q <= wp_q + 1'b1;
         if (do_rd) rp_q <= rp_q + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/dmaf_len_reg.sv
module dmaf_len_reg
   import dmaf_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_we,
   input  logic [CNT_W-1:0] cfg_len,
   output logic [CNT_W-1:0] len
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic [CNT_W-1:0] len_q;
   logic [CNT_W-1:0] len_d;

   assign len_d = CNT_W'(clamp_len(int'(cfg_len), DEPTH));
   assign len   = len_q;

   always_ff @(posedge clk) begin
      if (rst)         len_q <= DEPTH_C;
      else if (cfg_we) len_q <= len_d;
   end
endmodule

// File: rtl/dmaf_req.sv
module dmaf_req
   import dmaf_pkg::*;
#(
   parameter dmaf_dir_e DIR   = DIR_TX,
   parameter int        DEPTH = 16,
   parameter int        CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] level,
   input  logic [CNT_W-1:0] len,
   input  logic             ack,
   output logic             single,
   output logic             burst
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic want_single, want_burst;
   logic single_q, burst_q;

   generate
      if (DIR == DIR_TX) begin : g_tx
         logic [CNT_W-1:0] space;
         assign space       = DEPTH_C - level;
         assign want_single = (level != DEPTH_C);
         assign want_burst  = (space >= len);
      end else begin : g_rx
         assign want_single = (level != '0);
         assign want_burst  = (level >= len);
      end
   endgenerate

   // Requests are re-armed only one cycle after an acknowledge.
   always_ff @(posedge clk) begin
      if (rst || ack) begin
         single_q <= 1'b0;
         burst_q  <= 1'b0;
      end else begin
         single_q <= want_single;
         burst_q  <= want_burst;
      end
   end

   assign single = single_q;
   assign burst  = burst_q;
endmodule

// File: rtl/dma_req_fifo.sv
module dma_req_fifo
   import dmaf_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  level,
   input  logic              cfg_we,
   input  logic [CNT_W-1:0]  cfg_len,
   output logic [CNT_W-1:0]  burst_size,
   input  logic              tx_ack,
   output logic              tx_single,
   output logic              tx_burst,
   input  logic              rx_ack,
   output logic              rx_single,
   output logic              rx_burst,
   input  logic              err_clr,
   output logic              err_ovf,
   output logic              err_udf
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("dma_req_fifo: DEPTH must be a power of two >= 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("dma_req_fifo: DATA_W must be positive");
      end
   endgenerate

   logic ovf_evt, udf_evt;
   logic ovf_q, udf_q;

   dmaf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data),
      .level(level), .ovf_evt(ovf_evt), .udf_evt(udf_evt)
   );

   dmaf_len_reg #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_len (
      .clk(clk), .rst(rst),
      .cfg_we(cfg_we), .cfg_len(cfg_len), .len(burst_size)
   );

   dmaf_req #(.DIR(DIR_TX), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_tx (
      .clk(clk), .rst(rst), .level(level), .len(burst_size),
      .ack(tx_ack), .single(tx_single), .burst(tx_burst)
   );

   dmaf_req #(.DIR(DIR_RX), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_rx (
      .clk(clk), .rst(rst), .level(level), .len(burst_size),
      .ack(rx_ack), .single(rx_single), .burst(rx_burst)
   );

   // Sticky error flags; a fresh event outranks the clear.
   always_ff @(posedge clk) begin
      if (rst) begin
         ovf_q <= 1'b0;
         udf_q <= 1'b0;
      end else begin
         ovf_q <= ovf_evt | (ovf_q & ~err_clr);
         udf_q <= udf_evt | (udf_q & ~err_clr);
      end
   end

   assign err_ovf = ovf_q;
   assign err_udf = udf_q;
endmodule

// File: rtl/dma_req_fifo_chk.sv
module dma_req_fifo_chk #(
   parameter int DEPTH = 16,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst,
   input logic             wr_en,
   input logic             rd_en,
   input logic [CNT_W-1:0] level,
   input logic [CNT_W-1:0] burst_size,
   input logic             tx_ack,
   input logic             tx_single,
   input logic             tx_burst,
   input logic             rx_ack,
   input logic             rx_single,
   input logic             rx_burst,
   input logic             err_clr,
   input logic             err_ovf,
   input logic             err_udf
);
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

   logic armed_q;
   always_ff @(posedge clk) armed_q <= !rst;

   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> (level == '0) && !tx_single && !tx_burst && !rx_single && !rx_burst);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
      (level == DEPTH_C) && wr_en && !rd_en |=> (level == DEPTH_C) && err_ovf);

   p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
      (level == '0) && rd_en && !wr_en |=> (level == '0) && err_udf);

   p_tx_single_r5: assert property (@(posedge clk) disable iff (rst)
      armed_q && !$past(tx_ack) |-> tx_single == ($past(level) != DEPTH_C));

   p_rx_single_r6: assert property (@(posedge clk) disable iff (rst)
      armed_q && !$past(rx_ack) |-> rx_single == ($past(level) != '0));

   p_rx_burst_needs_data_r8: assert property (@(posedge clk) disable iff (rst)
      rx_burst |-> rx_single);

   p_tx_ack_mask_r9: assert property (@(posedge clk) disable iff (rst)
      tx_ack |=> !tx_single && !tx_burst);

   p_rx_ack_mask_r9: assert property (@(posedge clk) disable iff (rst)
      rx_ack |=> !rx_single && !rx_burst);

   p_ack_keeps_level_r10: assert property (@(posedge clk) disable iff (rst)
      (tx_ack || rx_ack) && !wr_en && !rd_en |=> $stable(level));

   p_len_range_r11: assert property (@(posedge clk) disable iff (rst)
      armed_q |-> (burst_size != '0) && (burst_size <= DEPTH_C));

   p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (rst)
      err_ovf && !err_clr |=> err_ovf);

   p_udf_sticky_r12: assert property (@(posedge clk) disable iff (rst)
      err_udf && !err_clr |=> err_udf);
endmodule

bind dma_req_fifo dma_req_fifo_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .level(level),
   .burst_size(burst_size), .tx_ack(tx_ack), .tx_single(tx_single),
   .tx_burst(tx_burst), .rx_ack(rx_ack), .rx_single(rx_single),
   .rx_burst(rx_burst), .err_clr(err_clr), .err_ovf(err_ovf), .err_udf(err_udf)
);

// File: tb/sim_dma_req_fifo.sv
module sim_dma_req_fifo;
   localparam int DATA_W = 16;
   localparam int DEPTH  = 16;
   localparam int CNT_W  = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst, wr_en, rd_en, cfg_we, tx_ack, rx_ack, err_clr;
   logic [DATA_W-1:0] wr_data, rd_data;
   logic [CNT_W-1:0]  level, cfg_len, burst_size;
   logic              tx_single, tx_burst, rx_single, rx_burst, err_ovf, err_udf;

   always #4 clk = ~clk;

   dma_req_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .level(level),
      .cfg_we(cfg_we), .cfg_len(cfg_len), .burst_size(burst_size),
      .tx_ack(tx_ack), .tx_single(tx_single), .tx_burst(tx_burst),
      .rx_ack(rx_ack), .rx_single(rx_single), .rx_burst(rx_burst),
      .err_clr(err_clr), .err_ovf(err_ovf), .err_udf(err_udf)
   );

   int checks = 0;
   int fails  = 0;

   // reference model
   logic [DATA_W-1:0] m_q[$];
   int m_len, m_ovf, m_udf, m_txs, m_txb, m_rxs, m_rxb;

   function automatic int ref_clamp(input int v);
      return (v == 0 || v > DEPTH) ? DEPTH : v;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(level == CNT_W'(m_q.size()), "R2/R10 level", int'(level), m_q.size());
      chk(burst_size == CNT_W'(m_len), "R11 burst_size", int'(burst_size), m_len);
      chk(tx_single == m_txs[0], "R5 tx_single", int'(tx_single), m_txs);
      chk(rx_single == m_rxs[0], "R6 rx_single", int'(rx_single), m_rxs);
      chk(tx_burst  == m_txb[0], "R7 tx_burst",  int'(tx_burst),  m_txb);
      chk(rx_burst  == m_rxb[0], "R8 rx_burst",  int'(rx_burst),  m_rxb);
      chk(err_ovf == m_ovf[0], "R3/R12 err_ovf", int'(err_ovf), m_ovf);
      chk(err_udf == m_udf[0], "R4/R12 err_udf", int'(err_udf), m_udf);
   endtask

   // One clock: drive at negedge, advance the model, compare at next negedge.
   task automatic tick(input bit w, input int wd, input bit r, input bit ta,
                       input bit ra, input bit cw, input int cl, input bit clr);
      int cnt;
      bit acc_w, acc_r;
      wr_en = w; wr_data = DATA_W'(wd); rd_en = r;
      tx_ack = ta; rx_ack = ra; cfg_we = cw; cfg_len = CNT_W'(cl); err_clr = clr;
      cnt = m_q.size();
      if (cnt > 0) // R2: head word visible before pop
         chk(rd_data == m_q[0], "R2 rd_data head", int'(rd_data), int'(m_q[0]));
      acc_w = w && (cnt < DEPTH);
      acc_r = r && (cnt > 0);
      // R9: ack silences its own channel for the next cycle
      m_txs = ta ? 0 : int'(cnt < DEPTH);
      m_txb = ta ? 0 : int'((DEPTH - cnt) >= m_len);
      m_rxs = ra ? 0 : int'(cnt > 0);
      m_rxb = ra ? 0 : int'(cnt >= m_len);
      m_ovf = (w && cnt == DEPTH) ? 1 : (clr ? 0 : m_ovf);
      m_udf = (r && cnt == 0) ? 1 : (clr ? 0 : m_udf);
      if (acc_r) void'(m_q.pop_front());
      if (acc_w) m_q.push_back(DATA_W'(wd));
      if (cw) m_len = ref_clamp(cl);
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      wr_en = 0; rd_en = 0; tx_ack = 0; rx_ack = 0; cfg_we = 0; err_clr = 0;
      wr_data = '0; cfg_len = '0;
      @(posedge clk); @(negedge clk);
      m_q.delete(); m_len = DEPTH; m_ovf = 0; m_udf = 0;
      m_txs = 0; m_txb = 0; m_rxs = 0; m_rxb = 0;
      compare_all(); // R1
      rst = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      int seed;
      seed = $urandom(32'd20240611);
      @(negedge clk);
      do_reset();
      idle(2);
      // R7/R8 with a 4-word block: fill to full, watching thresholds
      tick(0, 0, 0, 0, 0, 1, 4, 0);
      for (int i = 0; i < DEPTH; i++) tick(1, 100 + i, 0, 0, 0, 0, 0, 0);
      idle(1);
      // R3: overflow dropped, flag set; R12: it stays set
      tick(1, 999, 0, 0, 0, 0, 0, 0);
      idle(3);
      chk(err_ovf == 1'b1, "R12 ovf holds", int'(err_ovf), 1);
      // R12: new event in the clear cycle wins
      tick(1, 998, 0, 0, 0, 0, 0, 1);
      tick(0, 0, 0, 0, 0, 0, 0, 1);
      chk(err_ovf == 1'b0, "R12 ovf cleared", int'(err_ovf), 0);
      // R9/R10: acks (transfer or flush) drop requests, keep contents
      tick(0, 0, 0, 1, 1, 0, 0, 0);
      chk(!rx_single && !rx_burst, "R9 rx masked", int'({rx_single, rx_burst}), 0);
      tick(0, 0, 0, 0, 1, 0, 0, 0);
      tick(0, 0, 0, 0, 0, 0, 0, 0);
      chk(level == CNT_W'(DEPTH), "R10 level after acks", int'(level), DEPTH);
      // R2: drain in order; R4: underflow while a write is accepted
      for (int i = 0; i < DEPTH; i++) tick(0, 0, 1, 0, 0, 0, 0, 0);
      tick(0, 0, 1, 0, 0, 0, 0, 0);
      tick(1, 55, 1, 0, 0, 0, 0, 0);
      chk(level == 1 && err_udf, "R4 underflow with write", int'(level), 1);
      tick(0, 0, 1, 0, 0, 0, 0, 1);
      // R11: clamping of 0 and oversize, exact boundaries
      tick(0, 0, 0, 0, 0, 1, 0, 0);
      chk(burst_size == CNT_W'(DEPTH), "R11 len 0 clamps", int'(burst_size), DEPTH);
      tick(0, 0, 0, 0, 0, 1, DEPTH + 5, 0);
      chk(burst_size == CNT_W'(DEPTH), "R11 len oversize clamps", int'(burst_size), DEPTH);
      tick(0, 0, 0, 0, 0, 1, 1, 0);
      tick(1, 7, 0, 0, 0, 0, 0, 0);
      idle(1);
      chk(rx_burst == 1'b1, "R8 one word meets len 1", int'(rx_burst), 1);
      // randomized traffic with shifting write/read bias
      for (int ph = 0; ph < 8; ph++) begin
         int wb;
         wb = (ph % 2 == 0) ? 75 : 25;
         for (int i = 0; i < 500; i++) begin
            tick(($urandom % 100) < wb, int'($urandom % 65536), ($urandom % 100) < (100 - wb),
                 ($urandom % 10) == 0, ($urandom % 10) == 0,
                 ($urandom % 40) == 0, int'($urandom % (2 * DEPTH)),
                 ($urandom % 30) == 0);
         end
      end
      // R1: reset mid-stream
      tick(1, 1, 0, 0, 0, 1, 3, 0);
      do_reset();
      idle(2);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule